// File: doc/BRIEF.md
# LIN Slave Header Resynchronizer

This block sits beside the bit-rate generator of a LIN slave node and watches the receive line while the node waits for a frame header. It times every low period on the line in sample ticks. When a low period has the length of a break field, it accepts it. It then times the 0x55 sync byte that follows. From that timing it works out how many sample ticks one bit really spans, so the identifier and the rest of the frame are sampled at the rate the master actually sends.

The corrected samples-per-bit value is held until the surrounding logic signals the end of the response. The value then falls back to the nominal 32 for the next header. A master node, or a node with resynchronization disabled, never retunes: the value stays at 32 and the line is ignored. The block reports a break that qualifies, a break that does not, and a completed sync measurement, each as a one-clock pulse.

Top module: `lin_hdr_resync`

## Requirements
- R1: After reset, and whenever no header is in progress, `spb` is 32 and all three pulse outputs are low.
- R2: A low period is measured as the number of ticks that sample the line low. On the first tick that samples the line high again, the block reacts to the count L. If 352 <= L <= 896 (11 to 28 bit times of 32 ticks), `brk_ok` pulses for one clock. Otherwise `brk_bad` pulses for one clock. During either pulse `spb` is 32.
- R3: After an accepted break, the count m is the number of ticks from the tick that sees the first falling edge to the tick that sees the fifth falling edge (8 bit times of 0x55). The candidate value is floor((m + 4) / 8).
- R4: If the candidate lies in 26..38, `spb` takes it and `sync_done` pulses on the same clock edge.
- R5: If the candidate lies outside 26..38, no `sync_done` is produced and `spb` stays 32. The block returns to waiting for a break, so the next low period on the line is measured as a break.
- R6: Once the sync byte is accepted, line activity is ignored and `spb` holds its value until `resp_end` is seen high. From the next clock `spb` is 32 and break detection is re-armed.
- R7: While `is_master` or `resync_off` is high, from the next clock `spb` is 32, no pulse is produced and the line is ignored. This also applies when either flag rises in the middle of a frame.
- R8: The line is evaluated only on clocks where `tick` is high; line activity on other clocks has no effect.
- R9: `spb` is always either 32 or a value in 26..38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled sample strobe, one clock wide |
| rxd | input | 1 | Receive line, already synchronized to clk |
| is_master | input | 1 | Node is the bus master; blocks resynchronization |
| resync_off | input | 1 | Resynchronization disabled |
| resp_end | input | 1 | End of the response; restores the nominal timing |
| spb | output | 6 | Samples-per-bit value for the bit-rate generator |
| brk_ok | output | 1 | Pulse: break accepted |
| brk_bad | output | 1 | Pulse: low period refused as a break |
| sync_done | output | 1 | Pulse: sync measured and new `spb` applied |

## Verification
A wrong tick count or a stale falling-edge register shows up directly in the `spb` value published with `sync_done`. That is at most one clock after the fifth falling edge of the sync byte, and the bench compares it against the rounded span it drove. A state machine that fails to return to waiting is exposed when the next low period yields no break pulse. It is also exposed when a following pulse arrives that the scoreboard did not queue. A missed mode or end-of-response return shows as `spb` differing from 32 one clock after the flag.

// File: rtl/lin_hdr_resync.sv
module lin_hdr_resync #(
  parameter int NOM_SPB    = 32,
  parameter int BRK_MIN    = 11,
  parameter int BRK_MAX    = 28,
  parameter int SPB_LO     = 26,
  parameter int SPB_HI     = 38,
  parameter int SYNC_EDGES = 5,
  parameter int SPAN_BITS  = 8,
  parameter int CW         = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         rxd,
  input  logic                         is_master,
  input  logic                         resync_off,
  input  logic                         resp_end,
  output logic [$clog2(SPB_HI+1)-1:0]  spb,
  output logic                         brk_ok,
  output logic                         brk_bad,
  output logic                         sync_done
);
  localparam int SPBW = $clog2(SPB_HI + 1);
  localparam int SH   = $clog2(SPAN_BITS);
  localparam int EW   = $clog2(SYNC_EDGES);
  localparam logic [CW-1:0] BRK_LO_T = CW'(BRK_MIN * NOM_SPB);
  localparam logic [CW-1:0] BRK_HI_T = CW'(BRK_MAX * NOM_SPB);
  localparam logic [CW:0]   SUM_LO   = (CW+1)'(SPB_LO << SH);
  localparam logic [CW:0]   SUM_HI   = (CW+1)'((SPB_HI + 1) << SH);
  localparam logic [CW:0]   HALF     = (CW+1)'(SPAN_BITS / 2);
  localparam logic [SPBW-1:0] NOM    = SPBW'(NOM_SPB);

  typedef enum logic [1:0] {S_IDLE, S_BRK, S_SYNC, S_RESP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] edges;
  logic          rx_q;

  wire           fall    = rx_q & ~rxd;
  wire [CW-1:0]  cnt_inc = (&cnt) ? cnt : cnt + 1'b1;
  wire [CW:0]    nsum    = {1'b0, cnt_inc} + HALF;
  wire           in_rng  = (nsum >= SUM_LO) && (nsum < SUM_HI);
  wire           brk_len_ok = (cnt >= BRK_LO_T) && (cnt <= BRK_HI_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      edges <= '0;
      rx_q <= 1'b1;
      spb <= NOM;
      brk_ok <= 1'b0;
      brk_bad <= 1'b0;
      sync_done <= 1'b0;
    end else begin
      brk_ok <= 1'b0;
      brk_bad <= 1'b0;
      sync_done <= 1'b0;
      if (is_master || resync_off || resp_end) begin
        st <= S_IDLE;
        spb <= NOM;
      end else if (tick) begin
        rx_q <= rxd;
        case (st)
          S_IDLE: if (!rxd) begin
            st <= S_BRK;
            cnt <= CW'(1);
          end
          S_BRK: if (!rxd) cnt <= cnt_inc;
          else if (brk_len_ok) begin
            brk_ok <= 1'b1;
            edges <= '0;
            st <= S_SYNC;
          end else begin
            brk_bad <= 1'b1;
            st <= S_IDLE;
          end
          S_SYNC: if (fall && edges == '0) begin
            cnt <= '0;
            edges <= EW'(1);
          end else if (fall && edges == EW'(SYNC_EDGES - 1)) begin
            if (in_rng) begin
              spb <= SPBW'(nsum >> SH);
              sync_done <= 1'b1;
              st <= S_RESP;
            end else st <= S_IDLE;
          end else if (edges != '0) begin
            cnt <= cnt_inc;
            if (fall) edges <= edges + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module lin_hdr_resync_chk #(
  parameter int NOM_SPB = 32,
  parameter int SPB_LO  = 26,
  parameter int SPB_HI  = 38
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        is_master,
  input logic                        resync_off,
  input logic                        resp_end,
  input logic [$clog2(SPB_HI+1)-1:0] spb,
  input logic                        brk_ok,
  input logic                        brk_bad,
  input logic                        sync_done
);
  a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_ok, brk_bad, sync_done}));
  a_r2_brk_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ok || brk_bad) |-> spb == NOM_SPB);
  a_r4_change_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(spb) && spb != NOM_SPB) |-> sync_done);
  a_r6_resp_end_restores: assert property (@(posedge clk) disable iff (!rst_n)
    resp_end |=> spb == NOM_SPB);
  a_r7_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master || resync_off) |=> (spb == NOM_SPB && !brk_ok && !brk_bad && !sync_done));
  a_r9_spb_range: assert property (@(posedge clk) disable iff (!rst_n)
    spb == NOM_SPB || (spb >= SPB_LO && spb <= SPB_HI));
endmodule

bind lin_hdr_resync lin_hdr_resync_chk #(.NOM_SPB(NOM_SPB), .SPB_LO(SPB_LO), .SPB_HI(SPB_HI)) u_chk (.*);

// File: tb/sim_lin_hdr_resync.sv
module sim_lin_hdr_resync;
  logic clk = 0, rst_n = 0, tick = 0, rxd = 1;
  logic is_master = 0, resync_off = 0, resp_end = 0;
  logic [5:0] spb;
  logic brk_ok, brk_bad, sync_done;

  lin_hdr_resync u0 (.*);

  always #10 clk = ~clk;

  typedef struct { int kind; int val; string req; } ev_t;
  ev_t q[$];
  int total = 0, fails = 0, seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input int val, input string req);
    ev_t e;
    e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // kind: 0 brk_ok, 1 brk_bad, 2 sync_done; compared as kind*100+spb
  always @(negedge clk) begin
    if (rst_n && (brk_ok || brk_bad || sync_done)) begin
      int k;
      ev_t e;
      seen++;
      k = sync_done ? 2 : (brk_bad ? 1 : 0);
      if (q.size() == 0) chk(0, "unexpected pulse R2/R4", k*100 + int'(spb), -1);
      else begin
        e = q.pop_front();
        chk(k == e.kind && int'(spb) == e.val, e.req, k*100 + int'(spb), e.kind*100 + e.val);
      end
    end
  end

  task automatic send(input logic lvl, input int n);
    rxd = lvl;
    repeat (n) begin
      tick = 1; @(negedge clk);
      tick = 0; @(negedge clk);
    end
  endtask

  task automatic end_resp();
    resp_end = 1; @(negedge clk);
    resp_end = 0; @(negedge clk);
    chk(spb == 32, "R6 spb nominal after resp_end", spb, 32);
  endtask

  // L: break ticks, b: ticks per bit, d: extra ticks in start bit, act: expect activity
  task automatic header(input int L, input int b, input int d, input bit act);
    int ns;
    bit acc;
    acc = (L >= 352 && L <= 896);
    ns  = (8*b + d + 4) / 8;
    if (act) begin
      if (!acc) push(1, 32, "R2 break refused");
      else begin
        push(0, 32, "R2 break accepted");
        if (ns >= 26 && ns <= 38) push(2, ns, "R3/R4 sync value");
        else push(1, 32, "R5 line re-armed after sync reject");
      end
    end
    send(0, L);
    send(1, b);
    if (act && !acc) begin
      send(1, 20);
      return;
    end
    send(0, b + d);
    for (int i = 0; i < 8; i++) send(logic'(i % 2 == 0), b);
    send(1, b);
    if (act && ns >= 26 && ns <= 38) begin
      send(0, 2*b); send(1, 3*b); send(0, b);
      send(1, 2*b);
      chk(spb == 6'(ns), "R6 spb held through response", spb, ns);
      end_resp();
    end else begin
      send(1, 10);
      chk(spb == 32, act ? "R5 spb stays nominal" : "R7 spb stays nominal", spb, 32);
    end
    send(1, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(spb == 32, "R1 reset spb", spb, 32);
    chk(!brk_ok && !brk_bad && !sync_done, "R1 reset pulses", {brk_ok, brk_bad, sync_done}, 0);
    rst_n = 1;
    send(1, 10);

    header(416, 32, 0, 1);
    header(416, 30, 4, 1);
    header(416, 30, 3, 1);
    header(352, 38, 0, 1);
    header(896, 26, 0, 1);
    header(351, 32, 0, 1);
    header(897, 32, 0, 1);
    header(1100, 32, 0, 1);
    header(416, 24, 0, 1);
    header(416, 40, 0, 1);

    is_master = 1; @(negedge clk);
    s0 = seen;
    header(416, 30, 0, 0);
    chk(seen == s0, "R7 master ignores line", seen - s0, 0);
    is_master = 0;
    resync_off = 1; @(negedge clk);
    s0 = seen;
    header(416, 30, 0, 0);
    chk(seen == s0, "R7 resync_off ignores line", seen - s0, 0);
    resync_off = 0;

    push(0, 32, "R2 break accepted");
    push(2, 34, "R4 sync value");
    send(0, 416); send(1, 34); send(0, 34);
    for (int i = 0; i < 8; i++) send(logic'(i % 2 == 0), 34);
    send(1, 34);
    chk(spb == 34, "R4 spb applied", spb, 34);
    resync_off = 1; @(negedge clk);
    chk(spb == 32, "R7 mid-frame disable restores", spb, 32);
    resync_off = 0;
    send(1, 20);

    s0 = seen;
    rxd = 0; tick = 0;
    repeat (1000) @(negedge clk);
    rxd = 1;
    send(1, 5);
    chk(seen == s0, "R8 no tick no effect", seen - s0, 0);
    chk(spb == 32, "R8 spb nominal", spb, 32);

    chk(q.size() == 0, "R2/R4 all expected pulses seen", q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule